// File: doc/BRIEF.md
# Serial GPIO Pin Interrupt Unit

This block turns the input bits collected by a serial GPIO chain into interrupts. The chain delivers a fresh snapshot of every input pin once per burst. A pin is addressed by a port number (0 to NUM_PORTS-1) and a bit index (0 to NUM_BITS-1). Each pin has its own trigger type, level polarity, enable and sticky pending flag. On every burst, each pin's new value is compared with the value it had in the previous burst, or with its polarity setting. A pin that matches its trigger condition sets its pending flag.

Software programs the unit through a simple single-cycle write port and a combinational read port. Every per-pin register word is indexed by bit index, and its bit p stands for port p. Pending state is reported per bit index as a port-wide identity word, which is the pending flags masked by the enables. A single interrupt line combines all identity words behind a master enable. The serial shifting and the interrupt dispatch are handled elsewhere.

Top module: `sgpio_irq_unit`

Address map (NB = NUM_BITS, default 4): 0 configuration (bit 0 = master enable); 1..NB polarity[b]; NB+1..2NB trigger-low[b]; 2NB+1..3NB trigger-high[b]; 3NB+1..4NB enable[b]; 4NB+1..5NB acknowledge[b] (write only, reads 0); 5NB+1..6NB identity[b] (read only).

## Requirements
- R1: After reset, every register reads 0, no pin is pending, and `irq_o` is low. The remembered previous sample of every pin is 0.
- R2: Trigger type 0 is level mode. With polarity bit 0, a pin sampled 1 in a burst becomes pending. With polarity bit 1 (polarity register at address 1+b, bit p), a pin sampled 0 becomes pending.
- R3: Trigger type 1 sets pending when the burst value of the pin differs from its value in the previous burst.
- R4: Trigger type 2 sets pending only on a 1-to-0 change between consecutive bursts.
- R5: Trigger type 3 sets pending only on a 0-to-1 change between consecutive bursts.
- R6: A pin's 2-bit trigger type comes from two registers. Its low bit is bit p of the trigger register at address NB+1+b. Its high bit is bit p of the trigger register at address 2NB+1+b. Both read back as written.
- R7: A pending flag stays set after the input condition goes away, until it is acknowledged.
- R8: Writing a word to acknowledge address 4NB+1+b clears the pending flags of the ports whose bits are 1 and leaves the others alone. A level pin that is still active becomes pending again at the next burst. If an event and an acknowledge of the same pin fall in the same cycle, the event wins.
- R9: The identity word at address 5NB+1+b reads as pending AND enable (enable register at address 3NB+1+b). A pin that becomes pending while disabled shows up as soon as it is enabled.
- R10: `irq_o` is high exactly when the master enable (address 0, bit 0) is 1 and at least one identity bit is 1. Clearing the master enable leaves the pending flags untouched.
- R11: Pin inputs are evaluated, and the previous sample is updated, only in cycles where `smp_valid_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid_i | input | 1 | High for one cycle when a new burst snapshot is present |
| smp_bits_i | input | NUM_BITS*NUM_PORTS | Snapshot, pin (b,p) at index b*NUM_PORTS+p |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address, used for both write and read |
| reg_wdata_i | input | NUM_PORTS | Write data |
| reg_rdata_o | output | NUM_PORTS | Combinational read data for `reg_addr_i` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the unit with the defaults of 32 ports and 4 bit indices. This puts port 31 and bit index 3 within reach, as well as the split trigger banks at their far ends (addresses 8 and 12). With these values the bench can drive a pin at each extreme of the address map, check that an acknowledge racing an event in the same cycle does not lose the event, and check that a snapshot presented without the valid strobe leaves all pending state unchanged.

// File: rtl/sgpio_irq_pkg.sv
package sgpio_irq_pkg;

    typedef enum logic [1:0] {
        TRG_LEVEL    = 2'd0,
        TRG_ANY_EDGE = 2'd1,
        TRG_FALL     = 2'd2,
        TRG_RISE     = 2'd3
    } trig_e;

    // Register map, derived from the number of bit indices
    function automatic int pol_base(int nb);
        return 1;
    endfunction

    function automatic int trg_base(int nb);
        return 1 + nb;
    endfunction

    function automatic int en_base(int nb);
        return 1 + 3 * nb;
    endfunction

    function automatic int ack_base(int nb);
        return 1 + 4 * nb;
    endfunction

    function automatic int id_base(int nb);
        return 1 + 5 * nb;
    endfunction

    function automatic int addr_width(int nb);
        return $clog2(1 + 6 * nb);
    endfunction

    // Single-pin trigger evaluation
    function automatic logic trig_hit(trig_e t, logic cur, logic prev, logic pol);
        logic hit;
        case (t)
            TRG_LEVEL:    hit = cur ^ pol;
            TRG_ANY_EDGE: hit = cur ^ prev;
            TRG_FALL:     hit = prev & ~cur;
            TRG_RISE:     hit = ~prev & cur;
            default:      hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/sgpio_irq_regs.sv
module sgpio_irq_regs
    import sgpio_irq_pkg::*;
#(
    parameter int NUM_PORTS = 32,
    parameter int NUM_BITS  = 4,
    parameter int ADDR_W    = 5
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_i,
    input  logic [ADDR_W-1:0]                   addr_i,
    input  logic [NUM_PORTS-1:0]                wdata_i,
    output logic                                master_o,
    output logic [NUM_BITS-1:0][NUM_PORTS-1:0]  pol_o,
    output logic [NUM_BITS-1:0][NUM_PORTS-1:0]  trg_lo_o,
    output logic [NUM_BITS-1:0][NUM_PORTS-1:0]  trg_hi_o,
    output logic [NUM_BITS-1:0][NUM_PORTS-1:0]  en_o,
    output logic [NUM_BITS-1:0][NUM_PORTS-1:0]  ack_o
);

    localparam int PolBase = pol_base(NUM_BITS);
    localparam int TrgBase = trg_base(NUM_BITS);
    localparam int EnBase  = en_base(NUM_BITS);
    localparam int AckBase = ack_base(NUM_BITS);

    typedef struct packed {
        logic                               master;
        logic [NUM_BITS-1:0][NUM_PORTS-1:0] pol;
        logic [NUM_BITS-1:0][NUM_PORTS-1:0] trg_lo;
        logic [NUM_BITS-1:0][NUM_PORTS-1:0] trg_hi;
        logic [NUM_BITS-1:0][NUM_PORTS-1:0] en;
    } regs_t;

    regs_t regs_d, regs_q;
    int    a;

    always_comb begin
        regs_d = regs_q;
        ack_o  = '0;
        a      = int'(addr_i);
        if (wr_i) begin
            if (a == 0) begin
                regs_d.master = wdata_i[0];
            end
            for (int b = 0; b < NUM_BITS; b++) begin
                if (a == PolBase + b)            regs_d.pol[b]    = wdata_i;
                if (a == TrgBase + b)            regs_d.trg_lo[b] = wdata_i;
                if (a == TrgBase + NUM_BITS + b) regs_d.trg_hi[b] = wdata_i;
                if (a == EnBase + b)             regs_d.en[b]     = wdata_i;
                if (a == AckBase + b)            ack_o[b]         = wdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign master_o = regs_q.master;
    assign pol_o    = regs_q.pol;
    assign trg_lo_o = regs_q.trg_lo;
    assign trg_hi_o = regs_q.trg_hi;
    assign en_o     = regs_q.en;

endmodule

// File: rtl/sgpio_irq_detect.sv
module sgpio_irq_detect
    import sgpio_irq_pkg::*;
#(
    parameter int NUM_PORTS = 32,
    parameter int NUM_BITS  = 4
) (
    input  logic [NUM_BITS-1:0][NUM_PORTS-1:0] cur_i,
    input  logic [NUM_BITS-1:0][NUM_PORTS-1:0] prev_i,
    input  logic [NUM_BITS-1:0][NUM_PORTS-1:0] pol_i,
    input  logic [NUM_BITS-1:0][NUM_PORTS-1:0] trg_lo_i,
    input  logic [NUM_BITS-1:0][NUM_PORTS-1:0] trg_hi_i,
    output logic [NUM_BITS-1:0][NUM_PORTS-1:0] evt_o
);

    for (genvar gb = 0; gb < NUM_BITS; gb++) begin : g_bit
        for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
            assign evt_o[gb][gp] = trig_hit(trig_e'({trg_hi_i[gb][gp], trg_lo_i[gb][gp]}),
                                            cur_i[gb][gp], prev_i[gb][gp], pol_i[gb][gp]);
        end
    end

endmodule

// File: rtl/sgpio_irq_pend.sv
module sgpio_irq_pend #(
    parameter int NUM_PORTS = 32,
    parameter int NUM_BITS  = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               valid_i,
    input  logic [NUM_BITS-1:0][NUM_PORTS-1:0] cur_i,
    input  logic [NUM_BITS-1:0][NUM_PORTS-1:0] evt_i,
    input  logic [NUM_BITS-1:0][NUM_PORTS-1:0] ack_i,
    output logic [NUM_BITS-1:0][NUM_PORTS-1:0] prev_o,
    output logic [NUM_BITS-1:0][NUM_PORTS-1:0] pend_o
);

    typedef struct packed {
        logic [NUM_BITS-1:0][NUM_PORTS-1:0] prev;
        logic [NUM_BITS-1:0][NUM_PORTS-1:0] pend;
    } pend_t;

    pend_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = st_q.pend & ~ack_i;
        if (valid_i) begin
            // a new event outranks an acknowledge in the same cycle
            st_d.pend = st_d.pend | evt_i;
            st_d.prev = cur_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prev_o = st_q.prev;
    assign pend_o = st_q.pend;

endmodule

// File: rtl/sgpio_irq_unit.sv
module sgpio_irq_unit
    import sgpio_irq_pkg::*;
#(
    parameter  int NUM_PORTS = 32,
    parameter  int NUM_BITS  = 4,
    localparam int ADDR_W    = sgpio_irq_pkg::addr_width(NUM_BITS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          smp_valid_i,
    input  logic [NUM_BITS*NUM_PORTS-1:0] smp_bits_i,
    input  logic                          reg_wr_i,
    input  logic [ADDR_W-1:0]             reg_addr_i,
    input  logic [NUM_PORTS-1:0]          reg_wdata_i,
    output logic [NUM_PORTS-1:0]          reg_rdata_o,
    output logic                          irq_o
);

    localparam int PolBase = pol_base(NUM_BITS);
    localparam int TrgBase = trg_base(NUM_BITS);
    localparam int EnBase  = en_base(NUM_BITS);
    localparam int IdBase  = id_base(NUM_BITS);

    logic                               master_w;
    logic [NUM_BITS-1:0][NUM_PORTS-1:0] pol_w, trg_lo_w, trg_hi_w, en_w, ack_w;
    logic [NUM_BITS-1:0][NUM_PORTS-1:0] evt_w, prev_w, pend_w, ident_w, cur_w;
    int                                 ra;

    assign cur_w = smp_bits_i;

    sgpio_irq_regs #(
        .NUM_PORTS (NUM_PORTS),
        .NUM_BITS  (NUM_BITS),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (reg_wr_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .master_o (master_w),
        .pol_o    (pol_w),
        .trg_lo_o (trg_lo_w),
        .trg_hi_o (trg_hi_w),
        .en_o     (en_w),
        .ack_o    (ack_w)
    );

    sgpio_irq_detect #(
        .NUM_PORTS (NUM_PORTS),
        .NUM_BITS  (NUM_BITS)
    ) u_detect (
        .cur_i    (cur_w),
        .prev_i   (prev_w),
        .pol_i    (pol_w),
        .trg_lo_i (trg_lo_w),
        .trg_hi_i (trg_hi_w),
        .evt_o    (evt_w)
    );

    sgpio_irq_pend #(
        .NUM_PORTS (NUM_PORTS),
        .NUM_BITS  (NUM_BITS)
    ) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (smp_valid_i),
        .cur_i   (cur_w),
        .evt_i   (evt_w),
        .ack_i   (ack_w),
        .prev_o  (prev_w),
        .pend_o  (pend_w)
    );

    assign ident_w = pend_w & en_w;
    assign irq_o   = master_w & (|ident_w);

    always_comb begin
        reg_rdata_o = '0;
        ra          = int'(reg_addr_i);
        if (ra == 0) begin
            reg_rdata_o[0] = master_w;
        end
        for (int b = 0; b < NUM_BITS; b++) begin
            if (ra == PolBase + b)            reg_rdata_o = pol_w[b];
            if (ra == TrgBase + b)            reg_rdata_o = trg_lo_w[b];
            if (ra == TrgBase + NUM_BITS + b) reg_rdata_o = trg_hi_w[b];
            if (ra == EnBase + b)             reg_rdata_o = en_w[b];
            if (ra == IdBase + b)             reg_rdata_o = ident_w[b];
        end
    end

endmodule

// File: rtl/sgpio_irq_chk.sv
module sgpio_irq_chk #(
    parameter int NUM_PORTS = 32,
    parameter int NUM_BITS  = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          valid,
    input logic [NUM_BITS*NUM_PORTS-1:0] cur,
    input logic [NUM_BITS*NUM_PORTS-1:0] prev,
    input logic [NUM_BITS*NUM_PORTS-1:0] ack,
    input logic [NUM_BITS*NUM_PORTS-1:0] pend,
    input logic                          irq
);

    AST_PREV_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> prev == $past(cur)); // R11

    AST_PREV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(prev)); // R11

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && ack == '0) |=> $stable(pend)); // R7

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && ack != '0) |=> (pend & $past(ack)) == '0); // R8

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pend != '0); // R10

endmodule

bind sgpio_irq_unit sgpio_irq_chk #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_BITS  (NUM_BITS)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (smp_valid_i),
    .cur   (smp_bits_i),
    .prev  (prev_w),
    .ack   (ack_w),
    .pend  (pend_w),
    .irq   (irq_o)
);

// File: tb/sim_sgpio_irq_unit.sv
module sim_sgpio_irq_unit;

    localparam int NP  = 32;
    localparam int NB  = 4;
    localparam int AW  = 5;
    localparam int CFG = 0;
    localparam int POL = 1;
    localparam int TRG = 5;
    localparam int EN  = 13;
    localparam int ACK = 17;
    localparam int ID  = 21;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic [NB*NP-1:0]  smp_bits = '0;
    logic              reg_wr = 1'b0;
    logic [AW-1:0]     reg_addr = '0;
    logic [NP-1:0]     reg_wdata = '0;
    logic [NP-1:0]     reg_rdata;
    logic              irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sgpio_irq_unit #(.NUM_PORTS(NP), .NUM_BITS(NB)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_valid_i (smp_valid),
        .smp_bits_i  (smp_bits),
        .reg_wr_i    (reg_wr),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_o       (irq)
    );

    function automatic logic [NB*NP-1:0] pin(int b, int p);
        logic [NB*NP-1:0] v = '0;
        v[b*NP+p] = 1'b1;
        return v;
    endfunction

    task automatic check(bit ok, string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, logic [NP-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic burst(logic [NB*NP-1:0] v);
        @(negedge clk);
        smp_valid = 1'b1; smp_bits = v;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic burst_ack(logic [NB*NP-1:0] v, int a, logic [NP-1:0] d);
        @(negedge clk);
        smp_valid = 1'b1; smp_bits = v;
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        smp_valid = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic expect_reg(int a, logic [NP-1:0] exp, string tag);
        @(negedge clk);
        reg_addr = AW'(a);
        #1;
        check(reg_rdata === exp, tag, reg_rdata, exp);
    endtask

    task automatic expect_irq(logic exp, string tag);
        @(negedge clk);
        #1;
        check(irq === exp, tag, {{(NP-1){1'b0}}, irq}, {{(NP-1){1'b0}}, exp});
    endtask

    task automatic cleanup();
        for (int b = 0; b < NB; b++) begin
            wr(POL + b, '0);
            wr(TRG + b, '0);
            wr(TRG + NB + b, '0);
            wr(EN + b, '0);
        end
        burst('0);
        for (int b = 0; b < NB; b++) wr(ACK + b, '1);
        wr(CFG, 32'h1);
    endtask

    task automatic t_reset();
        expect_reg(CFG, '0, "R1 config after reset");
        expect_reg(EN + 3, '0, "R1 enable after reset");
        expect_reg(TRG + 7, '0, "R1 trigger after reset");
        for (int b = 0; b < NB; b++) expect_reg(ID + b, '0, "R1 identity after reset");
        expect_irq(1'b0, "R1 irq after reset");
    endtask

    task automatic t_level();
        cleanup();
        wr(EN + 0, 32'h1);
        burst(pin(0, 0));
        expect_reg(ID + 0, 32'h1, "R2 level high pends");
        expect_irq(1'b1, "R10 irq with pending pin");
        wr(ACK + 0, 32'h1);
        expect_reg(ID + 0, 32'h0, "R8 ack clears");
        expect_irq(1'b0, "R10 irq after ack");
        burst(pin(0, 0));
        expect_reg(ID + 0, 32'h1, "R8 level re-pends while active");
        cleanup();
        wr(POL + 1, 32'h20);
        wr(EN + 1, 32'h20);
        burst('0);
        expect_reg(ID + 1, 32'h20, "R2 level low pends on 0");
        wr(ACK + 1, '1);
        burst(pin(1, 5));
        expect_reg(ID + 1, 32'h0, "R2 level low idle on 1");
    endtask

    task automatic t_any();
        cleanup();
        wr(TRG + 2, 32'h8000_0000);
        wr(EN + 2, 32'h8000_0000);
        expect_reg(TRG + 2, 32'h8000_0000, "R6 trigger low readback");
        burst(pin(2, 31));
        expect_reg(ID + 2, 32'h8000_0000, "R3 any edge on rise");
        wr(ACK + 2, 32'h8000_0000);
        burst(pin(2, 31));
        expect_reg(ID + 2, 32'h0, "R3 any edge quiet when steady");
        burst('0);
        expect_reg(ID + 2, 32'h8000_0000, "R3 any edge on fall");
    endtask

    task automatic t_fall();
        cleanup();
        wr(TRG + NB + 3, 32'h80);
        wr(EN + 3, 32'h80);
        expect_reg(TRG + NB + 3, 32'h80, "R6 trigger high readback");
        burst(pin(3, 7));
        expect_reg(ID + 3, 32'h0, "R4 falling ignores rise");
        burst('0);
        expect_reg(ID + 3, 32'h80, "R4 falling edge pends");
    endtask

    task automatic t_rise();
        cleanup();
        wr(TRG + 0, 32'h1_0000);
        wr(TRG + NB + 0, 32'h1_0000);
        wr(EN + 0, 32'h1_0000);
        burst(pin(0, 16));
        expect_reg(ID + 0, 32'h1_0000, "R5 rising edge pends");
        burst('0);
        expect_reg(ID + 0, 32'h1_0000, "R7 pending sticks after input drops");
        wr(ACK + 0, 32'h1_0000);
        expect_reg(ID + 0, 32'h0, "R8 ack clears edge pin");
        burst('0);
        expect_reg(ID + 0, 32'h0, "R5 rising ignores steady low");
    endtask

    task automatic t_mask_master();
        cleanup();
        burst(pin(1, 2));
        expect_reg(ID + 1, 32'h0, "R9 disabled pin hidden");
        expect_irq(1'b0, "R9 no irq while disabled");
        wr(EN + 1, 32'h4);
        expect_reg(ID + 1, 32'h4, "R9 pending shows on enable");
        expect_irq(1'b1, "R9 irq on enable");
        wr(CFG, 32'h0);
        expect_irq(1'b0, "R10 master off blocks irq");
        expect_reg(ID + 1, 32'h4, "R10 master off keeps pending");
        wr(CFG, 32'h1);
        expect_irq(1'b1, "R10 master on restores irq");
        expect_reg(CFG, 32'h1, "R10 master readback");
    endtask

    task automatic t_ack_partial();
        cleanup();
        wr(EN + 0, 32'h18);
        burst(32'h18);
        expect_reg(ID + 0, 32'h18, "R8 two pins pending");
        wr(ACK + 0, 32'h08);
        expect_reg(ID + 0, 32'h10, "R8 partial ack");
        burst_ack(32'h18, ACK + 0, 32'h18);
        expect_reg(ID + 0, 32'h18, "R8 event wins over ack");
    endtask

    task automatic t_nosample();
        cleanup();
        wr(TRG + 3, 32'h1);
        wr(EN + 3, 32'h1);
        @(negedge clk);
        smp_bits = pin(3, 0);
        repeat (3) @(negedge clk);
        expect_reg(ID + 3, 32'h0, "R11 no change without valid");
        burst(pin(3, 0));
        expect_reg(ID + 3, 32'h1, "R11 change seen with valid");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_level();
        t_any();
        t_fall();
        t_rise();
        t_mask_master();
        t_ack_partial();
        t_nosample();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule